// File: doc/BRIEF.md
# Integrating Conversion Timing Controller

This block is the digital core of an integrating light-to-digital converter. An analog modulator outside the block produces a single-cycle pulse each time it has collected a fixed charge. The block counts those pulses over an integration window and keeps the latest count in a 16-bit result register. Software reaches the block through a plain byte-wide address/data register port. Address 00h holds the command byte. Addresses 01h and 02h give read-only access to the result, low byte first.

The window comes from one of two sources. In internal timing the window is a fixed number of clock cycles, and that number is set by a resolution field. In external timing the window lies between two consecutive sync pulses. During that window the block counts both the modulator pulses and the clock cycles that elapse. A field in the command byte then chooses which of the two counts the data addresses show.

The port carries no streaming data, so it has no valid/ready handshake. A register access completes in the cycle it is presented: a write takes effect at the next clock edge, and read data are combinational on the current address.

Top module: `integ_conv_ctrl`

## Requirements
- R1: After reset the command byte reads 00h, which means stopped, internal timing and 16-bit resolution. Addresses 01h and 02h both read 00h.
- R2: The command byte at address 00h reads back exactly as it was written. Its fields are: bit 7 run, bits 6:5 spare, bit 4 external timing, bits 3:2 resolution, bits 1:0 range. The range code has no effect on any count.
- R3: In internal timing with run set, the resolution code sets the window length: 00 gives 65536 cycles, 01 gives 4096, 10 gives 256 and 11 gives 16. After each window the result is reloaded with the number of pulse-high cycles in that window.
- R4: In internal timing the result for a window of 2^n cycles saturates at 2^n−1 and does not wrap.
- R5: While run is clear, nothing is counted and the result registers keep their values.
- R6: In external timing, a sync pulse outside a window opens a window and clears both counters. The pulse level on that cycle is ignored. The next sync pulse closes the window. It latches the elapsed-cycle count, equal to the number of clock edges from the opening sync to the closing sync, and it latches the pulse count for the cycles after the opening sync up to and including the closing one.
- R7: In external timing, a command whose bits 4:2 are 101 makes the data addresses show the cycle count. Bits 4:2 equal to 100 show the pulse count. Both counts are kept, whichever one is shown.
- R8: Address 01h returns the low byte of the shown value. Each read of 01h also captures the matching high byte, and address 02h returns that captured byte. A 01h-then-02h pair therefore always comes from one result, even if a new result lands between the two reads.
- R9: Any write to the command byte restarts the current window or sync phase from zero. Results already latched are kept.
- R10: In external timing both the pulse count and the cycle count saturate at FFFFh.
- R11: Writes to any address other than 00h are ignored. Reads of addresses above 02h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to capture the high byte) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| mod_pulse | input | 1 | Modulator pulse, one count per high cycle |
| ext_sync | input | 1 | Sync pulse bounding the external window |

## Verification
The internal window is driven with several pulse patterns: alternating pulses, a short burst at the start, pulses every third cycle, and pulses on every cycle. Together these separate a correct window length from an off-by-one, and a correct saturation limit from wrap-around. The same pattern is run under two range codes to show that the range changes nothing. Sync-bounded windows are run with sparse pulses and with dense pulses, including a pulse on the opening sync cycle. These tell the cycle count apart from the pulse count, and show whether the opening cycle is counted. A long saturated window, a command rewrite partway through a window, and a result that lands between the low-byte and high-byte reads cover the restart and snapshot rules.

// File: rtl/ictc_pkg.sv
package ictc_pkg;

  localparam int CNT_W = 16;
  localparam int REG_W = 8;

  typedef struct packed {
    logic       run;
    logic [1:0] spare;
    logic       ext;
    logic [1:0] res;
    logic [1:0] rng;
  } cmd_t;

  // resolution code that, with ext set, selects the cycle count for display
  localparam logic [1:0] RES_SHOW_TMR = 2'b01;

  // last cycle index (and saturation limit) of an internal window
  function automatic logic [CNT_W-1:0] win_last(input logic [1:0] res);
    return {CNT_W{1'b1}} >> (int'(res) * (CNT_W / 4));
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v,
                                               input logic [CNT_W-1:0] lim,
                                               input logic             step);
    return (step && (v != lim)) ? v + 1'b1 : v;
  endfunction

endpackage

// File: rtl/ictc_int_window.sv
module ictc_int_window
  import ictc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [1:0]       res_i,
  input  logic             pulse_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] val_o
);

  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] acc_nxt;

  always_comb begin
    last    = win_last(res_i);
    acc_nxt = sat_inc(acc_q, last, pulse_i);
    vld_o   = en_i && !restart_i && (wcnt_q == last);
    val_o   = acc_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !en_i) begin
      wcnt_q <= '0;
      acc_q  <= '0;
    end else if (wcnt_q == last) begin
      wcnt_q <= '0;
      acc_q  <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
      acc_q  <= acc_nxt;
    end
  end

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (wcnt_q <= last)) else $error("window index past end"); // R3
  AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> (val_o <= last)) else $error("result above limit"); // R4
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (wcnt_q == '0 && acc_q == '0)) else $error("counting while stopped"); // R5

endmodule

// File: rtl/ictc_ext_window.sv
module ictc_ext_window
  import ictc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             sync_i,
  input  logic             pulse_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] adc_o,
  output logic [CNT_W-1:0] tmr_o
);

  localparam logic [CNT_W-1:0] FULL = '1;

  logic             open_q;
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W-1:0] acc_nxt;
  logic [CNT_W-1:0] tmr_nxt;

  always_comb begin
    acc_nxt = sat_inc(acc_q, FULL, pulse_i);
    tmr_nxt = sat_inc(tmr_q, FULL, 1'b1);
    vld_o   = en_i && !restart_i && open_q && sync_i;
    adc_o   = acc_nxt;
    tmr_o   = tmr_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart_i || !en_i) begin
      open_q <= 1'b0;
      acc_q  <= '0;
      tmr_q  <= '0;
    end else if (sync_i) begin
      open_q <= !open_q;
      acc_q  <= '0;
      tmr_q  <= '0;
    end else if (open_q) begin
      acc_q  <= acc_nxt;
      tmr_q  <= tmr_nxt;
    end
  end

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !restart_i && sync_i && !open_q) |=> (open_q && acc_q == '0 && tmr_q == '0))
    else $error("window open did not clear"); // R6
  AST_ADC_LE_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (acc_q <= tmr_q)) else $error("more pulses than cycles"); // R10

endmodule

// File: rtl/ictc_regfile.sv
module ictc_regfile
  import ictc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output cmd_t              cmd_o,
  output logic              cmd_wr_o,
  input  logic [CNT_W-1:0]  adc_i,
  input  logic [CNT_W-1:0]  tmr_i
);

  localparam logic [ADDR_W-1:0] ADR_CMD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_LO  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_HI  = ADDR_W'(2);

  cmd_t             cmd_q;
  logic [REG_W-1:0] hold_q;
  logic [CNT_W-1:0] disp;
  logic             show_tmr;
  logic             lo_read;

  always_comb begin
    show_tmr = cmd_q.ext && (cmd_q.res == RES_SHOW_TMR);
    disp     = show_tmr ? tmr_i : adc_i;
    cmd_wr_o = wr_en_i && (addr_i == ADR_CMD);
    lo_read  = rd_en_i && (addr_i == ADR_LO);
    cmd_o    = cmd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      hold_q <= '0;
    end else begin
      if (cmd_wr_o) cmd_q <= cmd_t'(wdata_i);
      if (lo_read)  hold_q <= disp[CNT_W-1 -: REG_W];
    end
  end

  always_comb begin
    case (addr_i)
      ADR_CMD: rdata_o = cmd_q;
      ADR_LO:  rdata_o = disp[REG_W-1:0];
      ADR_HI:  rdata_o = hold_q;
      default: rdata_o = '0;
    endcase
  end

  AST_MSB_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    lo_read |=> (hold_q == $past(disp[CNT_W-1 -: REG_W]))) else $error("high byte not captured"); // R8
  AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr_o |=> $stable(cmd_q)) else $error("command changed without write"); // R11

endmodule

// File: rtl/integ_conv_ctrl.sv
module integ_conv_ctrl
  import ictc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              mod_pulse,
  input  logic              ext_sync
);

  cmd_t             cmd;
  logic             cmd_wr;
  logic             int_en;
  logic             ext_en;
  logic             int_vld;
  logic [CNT_W-1:0] int_val;
  logic             ext_vld;
  logic [CNT_W-1:0] ext_adc;
  logic [CNT_W-1:0] ext_tmr;
  logic [CNT_W-1:0] adc_q;
  logic [CNT_W-1:0] tmr_q;

  assign int_en = cmd.run && !cmd.ext;
  assign ext_en = cmd.run &&  cmd.ext;

  ictc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (reg_wr),
    .rd_en_i  (reg_rd),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .cmd_o    (cmd),
    .cmd_wr_o (cmd_wr),
    .adc_i    (adc_q),
    .tmr_i    (tmr_q)
  );

  ictc_int_window u_int (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (int_en),
    .restart_i (cmd_wr),
    .res_i     (cmd.res),
    .pulse_i   (mod_pulse),
    .vld_o     (int_vld),
    .val_o     (int_val)
  );

  ictc_ext_window u_ext (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (ext_en),
    .restart_i (cmd_wr),
    .sync_i    (ext_sync),
    .pulse_i   (mod_pulse),
    .vld_o     (ext_vld),
    .adc_o     (ext_adc),
    .tmr_o     (ext_tmr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_q <= '0;
      tmr_q <= '0;
    end else if (int_vld) begin
      adc_q <= int_val;
    end else if (ext_vld) begin
      adc_q <= ext_adc;
      tmr_q <= ext_tmr;
    end
  end

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_vld && !ext_vld) |=> ($stable(adc_q) && $stable(tmr_q))) else $error("result changed between conversions"); // R3
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_vld && ext_vld)) else $error("both timers completed together"); // R7

endmodule

// File: tb/integ_conv_ctrl_tb_top.sv
module integ_conv_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       mod_pulse = 1'b0;
  logic       ext_sync = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  integ_conv_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .mod_pulse (mod_pulse),
    .ext_sync  (ext_sync)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic step(input logic p, input logic s);
    mod_pulse = p; ext_sync = s;
    @(negedge clk);
    mod_pulse = 1'b0; ext_sync = 1'b0;
  endtask

  task automatic chk_pair(input string req, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd_reg(8'h01, lo);
    chk({req, " low byte"}, {8'h00, lo}, {8'h00, exp[7:0]});
    rd_reg(8'h02, hi);
    chk({req, " high byte"}, {8'h00, hi}, {8'h00, exp[15:8]});
  endtask

  // mode 0: pulses on the first k cycles; mode 1: every k-th cycle
  task automatic int_window(input string req, input logic [7:0] cmd, input int len,
                            input int mode, input int k);
    int cnt = 0;
    wr_reg(8'h00, cmd);
    for (int i = 0; i < len; i++) begin
      logic p;
      p = (mode == 0) ? (i < k) : ((i % k) == 0);
      if (p) cnt++;
      step(p, 1'b0);
    end
    chk_pair(req, 16'((cnt > len - 1) ? len - 1 : cnt));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_reg(8'h00, d); chk("R1 command after reset", {8'h00, d}, 16'h0000);
    rd_reg(8'h01, d); chk("R1 low byte after reset", {8'h00, d}, 16'h0000);
    rd_reg(8'h02, d); chk("R1 high byte after reset", {8'h00, d}, 16'h0000);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(8'h00, 8'h63);
    rd_reg(8'h00, d); chk("R2 command readback", {8'h00, d}, 16'h0063);
    wr_reg(8'h01, 8'hAA);
    rd_reg(8'h01, d); chk("R11 write to data ignored", {8'h00, d}, 16'h0000);
    wr_reg(8'h07, 8'h55);
    rd_reg(8'h00, d); chk("R11 command untouched by other write", {8'h00, d}, 16'h0063);
    rd_reg(8'h07, d); chk("R11 unused address reads zero", {8'h00, d}, 16'h0000);
  endtask

  task automatic t_internal();
    int_window("R3 16-cycle alternating", 8'h8C, 16, 1, 2);
    int_window("R3 16-cycle reload burst", 8'h8C, 16, 0, 5);
    int_window("R3 256-cycle every third", 8'h88, 256, 1, 3);
  endtask

  task automatic t_saturate();
    int_window("R4 4-bit saturation", 8'h8C, 16, 0, 16);
    int_window("R4 8-bit saturation", 8'h88, 256, 0, 256);
  endtask

  task automatic t_range();
    logic [7:0] d;
    int_window("R2 range 3 no effect", 8'h8F, 16, 1, 2);
    rd_reg(8'h00, d); chk("R2 range readback", {8'h00, d}, 16'h008F);
  endtask

  task automatic t_stop();
    wr_reg(8'h00, 8'h0F);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    chk_pair("R5 stopped keeps result", 16'd8);
  endtask

  task automatic t_restart();
    wr_reg(8'h00, 8'h8C);
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    int_window("R9 rewrite restarts window", 8'h8C, 16, 0, 3);
  endtask

  task automatic t_atomic();
    logic [7:0] d;
    wr_reg(8'h00, 8'h84);
    for (int i = 0; i < 4096; i++) step(i < 300, 1'b0);
    rd_reg(8'h01, d); chk("R8 low byte of first result", {8'h00, d}, 16'h002C);
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 4096 - 1 - 600; i++) step(1'b0, 1'b0);
    rd_reg(8'h02, d); chk("R8 high byte from same result", {8'h00, d}, 16'h0001);
    chk_pair("R8 R3 second 4096-cycle result", 16'd600);
  endtask

  task automatic t_external();
    wr_reg(8'h00, 8'h90);
    step(1'b0, 1'b1);
    for (int i = 1; i <= 100; i++) step((i % 4) == 0, i == 100);
    chk_pair("R6 R7 external pulse count", 16'd25);
    wr_reg(8'h00, 8'h94);
    chk_pair("R7 R9 external cycle count kept", 16'd100);
    step(1'b1, 1'b1);
    for (int i = 1; i <= 37; i++) step(1'b1, i == 37);
    chk_pair("R6 cycle count dense window", 16'd37);
    wr_reg(8'h00, 8'h90);
    chk_pair("R6 opening pulse ignored", 16'd37);
  endtask

  task automatic t_ext_sat();
    wr_reg(8'h00, 8'h90);
    step(1'b1, 1'b1);
    for (int i = 1; i <= 70000; i++) step(1'b1, i == 70000);
    chk_pair("R10 pulse count saturates", 16'hFFFF);
    wr_reg(8'h00, 8'h94);
    chk_pair("R10 cycle count saturates", 16'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_internal();
    t_saturate();
    t_range();
    t_stop();
    t_restart();
    t_atomic();
    t_external();
    t_ext_sat();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule